// File: doc/BRIEF.md
# Maskable Event Controller with Acknowledge Readout

This block keeps an 8-bit register of pending events and an 8-bit enable mask, and pulls an active-low interrupt line whenever an enabled event is pending. Events arrive as single-cycle strobes, as a one-second tick, or as a result from a polled peripheral bus. A polled result carries up to 16 reply bytes, which the block holds until software collects them.

Software works through two commands. The mask-write command carries one argument byte that replaces the mask. The acknowledge command carries no arguments and starts a response byte stream. When a bus result is pending, the stream carries the two bus-related pending bits followed by the stored reply, and only those two bits are cleared. Otherwise the stream is one byte holding the whole pending register, and every pending bit is cleared. The bus itself lies outside this block; only its results enter here.

Bit positions: bit 4 is the bus-result bit, bit 2 is the autopoll bit, bit 3 is the tick bit. The other bits are plain events.

Top module: `evt_ack_ctrl`

## Requirements
- R1: `irq_n` is low exactly when (pending AND mask) is non-zero. It follows the registered state, so a change made at a clock edge is visible on `irq_n` in the cycle after that edge.
- R2: After reset the pending register is 0x00, the mask is 0x18 (bus bit 4 and tick bit 3), `irq_n` is high and `rsp_valid` is low.
- R3: A `tick` pulse sets pending bit 3.
- R4: A mask write with `mask_nargs` equal to 1 replaces the mask with `mask_data`. A mask write with any other argument count has no effect.
- R5: An accepted acknowledge while bit 4 is pending streams `reply_len`+1 bytes on consecutive cycles, starting in the cycle after the command edge. Byte 0 is pending AND 0x14. Byte k (k ≥ 1) is reply byte k-1, and `rsp_last` marks the final byte. The acknowledge clears only bits 4 and 2 and zeroes the stored reply length. All other pending bits stay set.
- R6: An accepted acknowledge while bit 4 is clear streams one byte equal to the whole pending register, with `rsp_last` high, and clears all pending bits.
- R7: A poll result is taken only when bit 4 is clear, no response is streaming, and `poll_len` lies between 1 and 16. Taking it sets bits 4 and 2 and stores the length and bytes, with reply byte i taken from `poll_data[8i+7:8i]`. A rejected result changes nothing.
- R8: An event strobe or tick in the same cycle as an acknowledge clear takes priority, so that event stays pending after the acknowledge.
- R9: `evt_strobe` sets any pending bit except bits 4 and 2. Strobes on those two positions are ignored, because only the poll path sets them.
- R10: An acknowledge with a non-zero `ack_nargs`, or one issued while a response is streaming, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 8 | Per-bit event set strobes |
| tick | input | 1 | One-second tick pulse |
| poll_valid | input | 1 | Poll result offered |
| poll_len | input | 5 | Reply length of offered result |
| poll_data | input | 128 | Reply bytes, byte i in bits 8i+7:8i |
| mask_valid | input | 1 | Mask-write command |
| mask_nargs | input | 4 | Argument count of mask write |
| mask_data | input | 8 | New mask value |
| ack_valid | input | 1 | Acknowledge command |
| ack_nargs | input | 4 | Argument count of acknowledge |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of response |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The acknowledge clear and a new event can land on the same clock edge. The bench provokes this by raising a strobe together with the acknowledge command, and by offering a poll result and a repeated acknowledge throughout a running reply stream. Each case is judged at the ports. The first response byte must exclude the colliding strobe, and a second acknowledge must then return exactly that strobe. The stream must run undisturbed to its end, after which the interrupt must show that no new bus result was taken.

// File: rtl/evt_ack_pkg.sv
package evt_ack_pkg;

    localparam int EVT_W    = 8;
    localparam int BUS_BIT  = 4;
    localparam int AUTO_BIT = 2;
    localparam int TICK_BIT = 3;

    typedef logic [EVT_W-1:0] evt_vec_t;

    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,
        ACK_BUS  = 2'd1,
        ACK_ALL  = 2'd2
    } ack_kind_e;

    function automatic evt_vec_t one_hot(input int pos);
        evt_vec_t v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    localparam evt_vec_t BUS_PAIR   = one_hot(BUS_BIT) | one_hot(AUTO_BIT);
    localparam evt_vec_t RESET_MASK = one_hot(BUS_BIT) | one_hot(TICK_BIT);

endpackage

// File: rtl/evt_pending.sv
module evt_pending
    import evt_ack_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_vec_t  evt_strobe,
    input  logic      tick,
    input  logic      poll_take,
    input  ack_kind_e ack_kind,
    input  logic      mask_we,
    input  evt_vec_t  mask_val,
    output evt_vec_t  pend_q,
    output evt_vec_t  mask_q,
    output logic      irq_n
);

    evt_vec_t sets;
    evt_vec_t clears;

    always_comb begin
        sets = evt_strobe & ~BUS_PAIR;
        if (tick)      sets = sets | one_hot(TICK_BIT);
        if (poll_take) sets = sets | BUS_PAIR;
        case (ack_kind)
            ACK_BUS: clears = BUS_PAIR;
            ACK_ALL: clears = '1;
            default: clears = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= RESET_MASK;
        end else begin
            pend_q <= (pend_q & ~clears) | sets;
            if (mask_we) mask_q <= mask_val;
        end
    end

    assign irq_n = ~|(pend_q & mask_q);

    // R3
    tick_sets_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> pend_q[TICK_BIT]);

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> mask_q == $past(mask_val));

    // R5
    bus_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_kind == ACK_BUS) |=> (pend_q & BUS_PAIR) == '0);

    // R6
    all_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_kind == ACK_ALL && sets == '0) |=> pend_q == '0);

    // R8
    strobe_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_kind != ACK_NONE) |=>
            (pend_q & $past(evt_strobe & ~BUS_PAIR)) == $past(evt_strobe & ~BUS_PAIR));

endmodule

// File: rtl/evt_reply_store.sv
module evt_reply_store
    import evt_ack_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               poll_valid,
    input  logic [LEN_W-1:0]   poll_len,
    input  logic [DEPTH*8-1:0] poll_data,
    input  logic               bus_pending,
    input  logic               stream_busy,
    input  logic               ack_bus,
    input  logic [LEN_W-1:0]   rd_idx,
    output logic               poll_take,
    output logic [LEN_W-1:0]   len_q,
    output logic [7:0]         rd_byte
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0] mem [DEPTH];

    assign poll_take = poll_valid && !bus_pending && !stream_busy &&
                       (poll_len != '0) && (int'(poll_len) <= DEPTH);

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)            mem[g] <= '0;
            else if (poll_take) mem[g] <= poll_data[g*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            len_q <= '0;
        else if (poll_take) len_q <= poll_len;
        else if (ack_bus)   len_q <= '0;
    end

    always_comb begin
        rd_byte = '0;
        if (int'(rd_idx) < DEPTH) rd_byte = mem[rd_idx[IDX_W-1:0]];
    end

    // R7
    poll_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (poll_valid && (bus_pending || stream_busy) && !ack_bus) |=> $stable(len_q));

    // R5
    len_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ack_bus |=> len_q == '0);

endmodule

// File: rtl/evt_rsp_stream.sv
module evt_rsp_stream
    import evt_ack_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  ack_kind_e        ack_kind,
    input  evt_vec_t         head_byte,
    input  logic [LEN_W-1:0] reply_len,
    input  logic [7:0]       rd_byte,
    output logic [LEN_W-1:0] rd_idx,
    output logic             busy,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             rsp_last
);

    logic             busy_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] last_q;
    evt_vec_t         head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
            head_q <= '0;
        end else if (ack_kind != ACK_NONE) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            last_q <= (ack_kind == ACK_BUS) ? reply_len : '0;
            head_q <= head_byte;
        end else if (busy_q) begin
            if (idx_q == last_q) busy_q <= 1'b0;
            else                 idx_q  <= idx_q + 1'b1;
        end
    end

    assign busy      = busy_q;
    assign rsp_valid = busy_q;
    assign rd_idx    = idx_q - 1'b1;
    assign rsp_data  = (idx_q == '0) ? head_q : rd_byte;
    assign rsp_last  = busy_q && (idx_q == last_q);

    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> idx_q <= last_q);

    // R10
    stream_end_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_last |=> !rsp_valid);

endmodule

// File: rtl/evt_ack_ctrl.sv
module evt_ack_ctrl
    import evt_ack_pkg::*;
#(
    parameter int REPLY_DEPTH = 16,
    parameter int NARG_W      = 4,
    parameter int LEN_W       = $clog2(REPLY_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [7:0]               evt_strobe,
    input  logic                     tick,
    input  logic                     poll_valid,
    input  logic [LEN_W-1:0]         poll_len,
    input  logic [REPLY_DEPTH*8-1:0] poll_data,
    input  logic                     mask_valid,
    input  logic [NARG_W-1:0]        mask_nargs,
    input  logic [7:0]               mask_data,
    input  logic                     ack_valid,
    input  logic [NARG_W-1:0]        ack_nargs,
    output logic                     rsp_valid,
    output logic [7:0]               rsp_data,
    output logic                     rsp_last,
    output logic                     irq_n
);

    evt_vec_t         pend_q;
    evt_vec_t         mask_q;
    evt_vec_t         head_byte;
    ack_kind_e        ack_kind;
    logic             ack_take;
    logic             mask_we;
    logic             busy;
    logic             poll_take;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] rd_idx;
    logic [7:0]       rd_byte;

    assign mask_we  = mask_valid && (mask_nargs == NARG_W'(1));
    assign ack_take = ack_valid && (ack_nargs == '0) && !busy;

    always_comb begin
        ack_kind  = ACK_NONE;
        head_byte = pend_q;
        if (ack_take) begin
            if (pend_q[BUS_BIT]) begin
                ack_kind  = ACK_BUS;
                head_byte = pend_q & BUS_PAIR;
            end else begin
                ack_kind  = ACK_ALL;
            end
        end
    end

    evt_pending u_pending (
        .clk        (clk),
        .rst        (rst),
        .evt_strobe (evt_strobe),
        .tick       (tick),
        .poll_take  (poll_take),
        .ack_kind   (ack_kind),
        .mask_we    (mask_we),
        .mask_val   (mask_data),
        .pend_q     (pend_q),
        .mask_q     (mask_q),
        .irq_n      (irq_n)
    );

    evt_reply_store #(.DEPTH(REPLY_DEPTH), .LEN_W(LEN_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .poll_valid  (poll_valid),
        .poll_len    (poll_len),
        .poll_data   (poll_data),
        .bus_pending (pend_q[BUS_BIT]),
        .stream_busy (busy),
        .ack_bus     (ack_kind == ACK_BUS),
        .rd_idx      (rd_idx),
        .poll_take   (poll_take),
        .len_q       (len_q),
        .rd_byte     (rd_byte)
    );

    evt_rsp_stream #(.LEN_W(LEN_W)) u_stream (
        .clk       (clk),
        .rst       (rst),
        .ack_kind  (ack_kind),
        .head_byte (head_byte),
        .reply_len (len_q),
        .rd_byte   (rd_byte),
        .rd_idx    (rd_idx),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last)
    );

    // R10
    busy_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !rsp_last) |=> rsp_valid);

    // R7
    poll_sets_chk: assert property (@(posedge clk) disable iff (rst)
        poll_take |=> pend_q[BUS_BIT] && pend_q[AUTO_BIT]);

endmodule

// File: tb/test_evt_ack_ctrl.sv
module test_evt_ack_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       evt_strobe = '0;
    logic             tick = 1'b0;
    logic             poll_valid = 1'b0;
    logic [4:0]       poll_len = '0;
    logic [DEPTH*8-1:0] poll_data = '0;
    logic             mask_valid = 1'b0;
    logic [3:0]       mask_nargs = '0;
    logic [7:0]       mask_data = '0;
    logic             ack_valid = 1'b0;
    logic [3:0]       ack_nargs = '0;
    logic             rsp_valid;
    logic [7:0]       rsp_data;
    logic             rsp_last;
    logic             irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_ack_ctrl i_evt_ack_ctrl (
        .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .tick(tick),
        .poll_valid(poll_valid), .poll_len(poll_len), .poll_data(poll_data),
        .mask_valid(mask_valid), .mask_nargs(mask_nargs), .mask_data(mask_data),
        .ack_valid(ack_valid), .ack_nargs(ack_nargs),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .irq_n(irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rbyte(input int seed, input int i);
        return 8'(seed + i * 3);
    endfunction

    task automatic wr_mask(input logic [7:0] m, input logic [3:0] n);
        mask_valid = 1'b1; mask_nargs = n; mask_data = m;
        @(negedge clk);
        mask_valid = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] p);
        evt_strobe = p;
        @(negedge clk);
        evt_strobe = '0;
    endtask

    task automatic load_poll(input int len, input int seed);
        for (int i = 0; i < DEPTH; i++) poll_data[i*8 +: 8] = rbyte(seed, i);
        poll_len = 5'(len);
    endtask

    task automatic poll(input int len, input int seed);
        load_poll(len, seed);
        poll_valid = 1'b1;
        @(negedge clk);
        poll_valid = 1'b0;
    endtask

    task automatic ack_expect(input string req, input logic [7:0] head,
                              input int n, input int seed);
        ack_valid = 1'b1; ack_nargs = '0;
        @(negedge clk);
        ack_valid = 1'b0;
        chk({req, " valid0"}, int'(rsp_valid), 1);
        chk({req, " head"}, int'(rsp_data), int'(head));
        chk({req, " last0"}, int'(rsp_last), int'(n == 0));
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            chk({req, " valid"}, int'(rsp_valid), 1);
            chk({req, " byte"}, int'(rsp_data), int'(rbyte(seed, k - 1)));
            chk({req, " last"}, int'(rsp_last), int'(k == n));
        end
        @(negedge clk);
        chk({req, " end"}, int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk("R2 irq_n", int'(irq_n), 1);
        chk("R2 rsp_valid", int'(rsp_valid), 0);
        // R2 reset mask enables tick, R3 tick sets bit 3
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R2 R3 tick irq", int'(irq_n), 0);
        ack_expect("R3 R6 tick ack", 8'h08, 0, 0);
        chk("R6 irq after", int'(irq_n), 1);

        // R1 R6 R9: sweep all masks with varied strobe patterns
        for (int m = 0; m < 256; m++) begin
            logic [7:0] raw, pe;
            raw = 8'((m * 73 + 5) & 8'hFF);
            pe  = raw & ~8'h14;
            wr_mask(8'(m), 4'd1);
            strobe(raw);
            chk("R1 R9 irq sweep", int'(irq_n), int'(((pe & 8'(m)) == 0)));
            ack_expect("R6 R9 sweep ack", pe, 0, 0);
            chk("R6 irq clear", int'(irq_n), 1);
        end

        // R5 R7: every reply length, with another event left pending
        for (int len = 1; len <= DEPTH; len++) begin
            wr_mask(8'h10, 4'd1);
            strobe(8'h02);
            poll(len, len * 11);
            chk("R7 poll irq", int'(irq_n), 0);
            ack_expect("R5 bus ack", 8'h14, len, len * 11);
            chk("R5 bus cleared", int'(irq_n), 1);
            wr_mask(8'h02, 4'd1);
            chk("R5 other kept", int'(irq_n), 0);
            ack_expect("R5 R6 rest", 8'h02, 0, 0);
        end

        // R7 reject while bus pending
        wr_mask(8'h10, 4'd1);
        poll(3, 40);
        poll(5, 90);
        ack_expect("R7 second poll rejected", 8'h14, 3, 40);
        // R7 lengths out of range
        poll(0, 1);
        chk("R7 len0 rejected", int'(irq_n), 1);
        poll(17, 1);
        chk("R7 len17 rejected", int'(irq_n), 1);

        // R7 R10: poll offered and ack repeated during a stream
        poll(4, 7);
        load_poll(2, 200);
        ack_valid = 1'b1; ack_nargs = '0; poll_valid = 1'b1;
        @(negedge clk);
        chk("R10 stream head", int'(rsp_data), 8'h14);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R10 stream byte", int'(rsp_data), int'(rbyte(7, k - 1)));
        end
        chk("R10 stream last", int'(rsp_last), 1);
        ack_valid = 1'b0; poll_valid = 1'b0;
        @(negedge clk);
        chk("R10 no restart", int'(rsp_valid), 0);
        chk("R7 busy poll rejected", int'(irq_n), 1);

        // R10 ack with arguments ignored; R4 mask write with 2 args ignored
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        ack_valid = 1'b1; ack_nargs = 4'd1;
        @(negedge clk);
        ack_valid = 1'b0; ack_nargs = '0;
        chk("R10 nargs ack ignored", int'(rsp_valid), 0);
        wr_mask(8'h08, 4'd2);
        chk("R4 bad nargs ignored", int'(irq_n), 1);
        wr_mask(8'h08, 4'd1);
        chk("R4 mask applied", int'(irq_n), 0);
        ack_expect("R4 R10 tick kept", 8'h08, 0, 0);

        // R8 strobe collides with acknowledge clear
        wr_mask(8'h00, 4'd1);
        strobe(8'h02);
        ack_valid = 1'b1; evt_strobe = 8'h41;
        @(negedge clk);
        ack_valid = 1'b0; evt_strobe = '0;
        chk("R8 head excludes strobe", int'(rsp_data), 8'h02);
        @(negedge clk);
        ack_expect("R8 strobe survived", 8'h41, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule